// File: doc/BRIEF.md
# IDE Channel Address Decoder

This block sits in front of a two-channel disk controller and routes each I/O access to the right place. It holds five address windows: command and control for the primary channel, command and control for the secondary channel, and one bus-master window. Each window is a programmable base plus a fixed size. For every request it reports which window was hit, the offset of the access inside that window, the channel the access belongs to, and the index of the drive that should handle it.

Each channel has a master and a slave drive. The block watches writes to the drive/head select register in each command window and keeps a shadow copy of the device-select bit for that channel. The drive index is formed from the channel and this shadow bit. The bus-master window is shared by both channels. Its lower offsets belong to the primary channel and its upper offsets to the secondary channel.

The block only accepts access widths of 1, 2 or 4 bytes. A 4-byte access is allowed only in the bus-master window. Any illegal access, or an address that hits no window, gives a one-cycle error pulse instead of a decoded result. A global I/O-enable input gates all decoding. Results are registered and appear one cycle after the request.

Top module: `ide_chan_decode`

## Requirements
- R1: An access with `io_en` high whose address satisfies base <= addr < base + size for a window gives a decoded result one cycle later. In that result `rsp_valid` is 1, `rsp_offset` is addr − base, and `rsp_region` is 1 for a command window, 2 for a control window and 3 for the bus-master window. The default sizes are 8 for command, 4 for control and 16 for bus-master.
- R2: When windows overlap, the first hit wins in this order: primary command, primary control, secondary command, secondary control, bus-master.
- R3: An enabled access that hits no window raises `rsp_err` for one cycle, with `rsp_valid` and all decoded fields at 0. `rsp_valid` and `rsp_err` are never 1 together.
- R4: In the bus-master window, offsets below `BM_SPLIT` (default 8) report `rsp_secondary` = 0. All other offsets report 1. The two command/control pairs report 0 (primary) and 1 (secondary).
- R5: A legal write at offset `SEL_OFFSET` (default 6) of a command window loads that channel's shadow device bit from bit 4 of `req_wbyte`. Reads do not change the bit, illegal writes do not change it, and the other channel's bit is left untouched.
- R6: `rsp_drive` = 2 × channel + shadow bit of that channel, where channel is 0 for primary and 1 for secondary. A select write reports the newly written bit. The bus-master window uses the bit of the channel it maps to.
- R7: `req_size` must be 1, 2 or 4 bytes. Any other value gives `rsp_err`.
- R8: A 4-byte access to a command or control window gives `rsp_err`. A 4-byte access to the bus-master window is legal.
- R9: While `io_en` is 0, a request produces neither `rsp_valid` nor `rsp_err` and does not change the shadow bits.
- R10: `bar_we` with `bar_idx` 0..4 loads the base of the windows in the R2 order, and the new base is used from the next cycle. A value of zero, or an index of 5..7, leaves every base unchanged.
- R11: After reset all outputs are 0, both shadow bits are 0 (master), and all bases are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_en | input | 1 | I/O decode enable |
| bar_we | input | 1 | Base-address load strobe |
| bar_idx | input | 3 | Window selected for the base load (0..4) |
| bar_val | input | ADDR_W | Base address to load |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Request address |
| req_size | input | 3 | Access width in bytes |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_wbyte | input | 8 | Low byte of the write data |
| rsp_valid | output | 1 | Decoded result present |
| rsp_err | output | 1 | One-cycle error pulse (miss or illegal access) |
| rsp_offset | output | ADDR_W | Offset inside the window that was hit |
| rsp_region | output | 2 | 0 none, 1 command, 2 control, 3 bus-master |
| rsp_secondary | output | 1 | 0 primary channel, 1 secondary channel |
| rsp_drive | output | 2 | Drive index 0..3 |

## Verification
Every decoded result and every error pulse belongs to the request sampled at the previous rising edge. A shadow-bit update is already visible in the drive index of the select write that causes it. A base load changes decoding from the next cycle on. The bench applies inputs on the falling edge and predicts that cycle's outcome from its own model of the window bases and shadow bits. At the following falling edge, after the single register stage, it compares every output. Idle and disabled cycles are compared the same way, so a missing result, an extra result or a stray pulse is caught in the cycle where it appears.

// File: rtl/ide_dec_pkg.sv
// Package: shared types and helpers for the IDE channel address decoder.
// Assumes five windows in fixed priority order: pri cmd, pri ctl, sec cmd,
// sec ctl, bus-master.
package ide_dec_pkg;

    localparam int NUM_WIN   = 5;
    localparam int WIN_IDX_W = $clog2(NUM_WIN);

    typedef enum logic [1:0] {
        RG_NONE = 2'd0,
        RG_CMD  = 2'd1,
        RG_CTL  = 2'd2,
        RG_BM   = 2'd3
    } region_e;

    // Map a window index to its region kind.
    function automatic region_e win_region(logic [WIN_IDX_W-1:0] idx);
        case (idx)
            3'd0, 3'd2: win_region = RG_CMD;
            3'd1, 3'd3: win_region = RG_CTL;
            3'd4:       win_region = RG_BM;
            default:    win_region = RG_NONE;
        endcase
    endfunction

endpackage

// File: rtl/ide_win_match.sv
// Module: one address window made of a programmable base and a fixed size.
// It reports a hit and the offset of the address from the base.
// Assumes the base loads only on a nonzero value and resets to zero.
module ide_win_match #(
    parameter int ADDR_W = 16,
    parameter int SIZE   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [ADDR_W-1:0] offset
);

    logic [ADDR_W-1:0] base_q;

    // Base register: a zero value is ignored.
    always_ff @(posedge clk) begin
        if (!rst_n)
            base_q <= '0;
        else if (load && (load_val != '0))
            base_q <= load_val;
    end

    // Range compare and offset generation.
    always_comb begin
        offset = addr - base_q;
        hit    = (addr >= base_q) && (offset < ADDR_W'(SIZE));
    end

    // R10
    zero_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && (load_val == '0)) |=> $stable(base_q));

    // R10
    base_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && (load_val != '0)) |=> (base_q == $past(load_val)));

endmodule

// File: rtl/ide_prio_sel.sv
// Module: fixed-priority selector over the window hits. The lowest index wins.
// Assumes hit[k] and off_in[k] come from window k.
module ide_prio_sel
    import ide_dec_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [NUM_WIN-1:0]   hit,
    input  logic [ADDR_W-1:0]    off_in [NUM_WIN],
    output logic                 any_hit,
    output logic [WIN_IDX_W-1:0] win_idx,
    output logic [ADDR_W-1:0]    sel_off
);

    // Scan from the lowest priority upward so the highest priority wins.
    always_comb begin
        any_hit = 1'b0;
        win_idx = '0;
        sel_off = '0;
        for (int k = NUM_WIN - 1; k >= 0; k--) begin
            if (hit[k]) begin
                any_hit = 1'b1;
                win_idx = WIN_IDX_W'(k);
                sel_off = off_in[k];
            end
        end
    end

endmodule

// File: rtl/ide_dev_shadow.sv
// Module: per-channel shadow of the master/slave select bit.
// The looked-up bit forwards an update made in the same cycle.
// Assumes at most one update per cycle.
module ide_dev_shadow (
    input  logic clk,
    input  logic rst_n,
    input  logic upd,
    input  logic upd_ch,
    input  logic upd_val,
    input  logic look_ch,
    output logic look_val
);

    logic [1:0] dev_q;

    // Shadow bits: reset to master, load on a snooped select write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dev_q <= 2'b00;
        else if (upd)
            dev_q[upd_ch] <= upd_val;
    end

    // Lookup with same-cycle forwarding.
    always_comb begin
        look_val = (upd && (upd_ch == look_ch)) ? upd_val : dev_q[look_ch];
    end

    // R5
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(dev_q));

    // R5
    shadow_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> (dev_q[$past(upd_ch)] == $past(upd_val)) &&
                (dev_q[!$past(upd_ch)] == $past(dev_q[!upd_ch])));

endmodule

// File: rtl/ide_chan_decode.sv
// Module: top of the IDE channel address decoder.
// It decodes a request against five windows, checks the access width,
// snoops select writes, and registers the routing result for one cycle.
// Assumes one request per cycle and that req_size is the width in bytes.
module ide_chan_decode
    import ide_dec_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int CMD_SIZE   = 8,
    parameter int CTL_SIZE   = 4,
    parameter int BM_SIZE    = 16,
    parameter int BM_SPLIT   = 8,
    parameter int SEL_OFFSET = 6,
    parameter int DEV_BIT    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_en,
    input  logic              bar_we,
    input  logic [2:0]        bar_idx,
    input  logic [ADDR_W-1:0] bar_val,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_size,
    input  logic              req_write,
    input  logic [7:0]        req_wbyte,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [ADDR_W-1:0] rsp_offset,
    output logic [1:0]        rsp_region,
    output logic              rsp_secondary,
    output logic [1:0]        rsp_drive
);

    // Size of window k in priority order.
    function automatic int win_size(int k);
        case (k)
            0, 2:    win_size = CMD_SIZE;
            1, 3:    win_size = CTL_SIZE;
            default: win_size = BM_SIZE;
        endcase
    endfunction

    logic [NUM_WIN-1:0]   win_hit;
    logic [ADDR_W-1:0]    win_off [NUM_WIN];
    logic                 any_hit;
    logic [WIN_IDX_W-1:0] win_idx;
    logic [ADDR_W-1:0]    sel_off;
    region_e              sel_region;
    logic                 sel_sec;
    logic                 size_ok;
    logic                 go;
    logic                 legal;
    logic                 snoop;
    logic                 dev_bit;

    // Window instances, one per address window.
    for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
        ide_win_match #(
            .ADDR_W (ADDR_W),
            .SIZE   (win_size(k))
        ) u_win (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (bar_we && (bar_idx == 3'(k))),
            .load_val (bar_val),
            .addr     (req_addr),
            .hit      (win_hit[k]),
            .offset   (win_off[k])
        );
    end

    ide_prio_sel #(.ADDR_W(ADDR_W)) u_sel (
        .hit     (win_hit),
        .off_in  (win_off),
        .any_hit (any_hit),
        .win_idx (win_idx),
        .sel_off (sel_off)
    );

    // Region, channel, legality and snoop decode for the current request.
    always_comb begin
        sel_region = any_hit ? win_region(win_idx) : RG_NONE;
        if (sel_region == RG_BM)
            sel_sec = (sel_off >= ADDR_W'(BM_SPLIT));
        else
            sel_sec = (win_idx == 3'd2) || (win_idx == 3'd3);
        size_ok = ((req_size == 3'd1) || (req_size == 3'd2) || (req_size == 3'd4)) &&
                  !((req_size == 3'd4) && (sel_region != RG_BM));
        go      = req_valid && io_en;
        legal   = go && any_hit && size_ok;
        snoop   = legal && req_write && (sel_region == RG_CMD) &&
                  (sel_off == ADDR_W'(SEL_OFFSET));
    end

    ide_dev_shadow u_dev (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd      (snoop),
        .upd_ch   (sel_sec),
        .upd_val  (req_wbyte[DEV_BIT]),
        .look_ch  (sel_sec),
        .look_val (dev_bit)
    );

    // Response register: a decoded result, an error pulse, or idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !legal) begin
            rsp_valid     <= 1'b0;
            rsp_err       <= rst_n && go && !legal;
            rsp_offset    <= '0;
            rsp_region    <= RG_NONE;
            rsp_secondary <= 1'b0;
            rsp_drive     <= 2'd0;
        end else begin
            rsp_valid     <= 1'b1;
            rsp_err       <= 1'b0;
            rsp_offset    <= sel_off;
            rsp_region    <= sel_region;
            rsp_secondary <= sel_sec;
            rsp_drive     <= {sel_sec, dev_bit};
        end
    end

    logic unused_wbyte;
    assign unused_wbyte = ^req_wbyte;

    // R9
    io_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !io_en) |=> (!rsp_valid && !rsp_err));

    // R3
    resp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && rsp_err));

    // R4
    bm_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_region == RG_BM)) |->
            (rsp_secondary == (rsp_offset >= ADDR_W'(BM_SPLIT))));

    // R8
    wide_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && io_en && (req_size == 3'd4) && (sel_region != RG_BM)) |=> rsp_err);

endmodule

// File: tb/sim_ide_chan_decode.sv
`timescale 1ns/1ps
// Bench: a behavioural model of the bases and shadow bits predicts each
// cycle's outputs; every cycle is compared one clock after the inputs are applied.
module sim_ide_chan_decode;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          io_en = 1'b0;
    logic          bar_we = 1'b0;
    logic [2:0]    bar_idx = '0;
    logic [AW-1:0] bar_val = '0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [2:0]    req_size = '0;
    logic          req_write = 1'b0;
    logic [7:0]    req_wbyte = '0;
    logic          rsp_valid, rsp_err, rsp_secondary;
    logic [AW-1:0] rsp_offset;
    logic [1:0]    rsp_region, rsp_drive;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    int base [5];
    int wsz  [5] = '{8, 4, 8, 4, 16};
    int dev  [2];

    always #2.5 clk = ~clk;

    ide_chan_decode u0 (
        .clk(clk), .rst_n(rst_n), .io_en(io_en),
        .bar_we(bar_we), .bar_idx(bar_idx), .bar_val(bar_val),
        .req_valid(req_valid), .req_addr(req_addr), .req_size(req_size),
        .req_write(req_write), .req_wbyte(req_wbyte),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_offset(rsp_offset),
        .rsp_region(rsp_region), .rsp_secondary(rsp_secondary), .rsp_drive(rsp_drive)
    );

    // Predict, advance one clock, update the model, compare.
    task automatic step(input string tag);
        logic [22:0] exp_v, act_v;
        int k, off, sec, reg_k, dnew, hit;
        bit legal, upd;
        exp_v = '0;
        upd = 1'b0;
        hit = 0; k = 0; off = 0; sec = 0; dnew = 0;
        if (rst_n && req_valid && io_en) begin
            for (int i = 0; i < 5; i++)
                if (hit == 0 && int'(req_addr) >= base[i] && int'(req_addr) < base[i] + wsz[i]) begin
                    hit = 1; k = i; off = int'(req_addr) - base[i];
                end
            legal = (hit == 1) && (req_size == 1 || req_size == 2 || req_size == 4) &&
                    !(req_size == 4 && k < 4);
            if (!legal) exp_v[21] = 1'b1;
            else begin
                reg_k = (k == 4) ? 3 : ((k % 2 == 0) ? 1 : 2);
                sec   = (k == 4) ? ((off >= 8) ? 1 : 0) : ((k >= 2) ? 1 : 0);
                dnew  = dev[sec];
                if (req_write && reg_k == 1 && off == 6) begin
                    upd = 1'b1; dnew = int'(req_wbyte[4]);
                end
                exp_v = {1'b1, 1'b0, AW'(off), 2'(reg_k), 1'(sec), 1'(sec), 1'(dnew)};
            end
        end
        @(posedge clk);
        if (!rst_n) begin
            foreach (base[i]) base[i] = 0;
            dev[0] = 0; dev[1] = 0;
        end else begin
            if (upd) dev[sec] = dnew;
            if (bar_we && bar_idx < 5 && bar_val != 0) base[bar_idx] = int'(bar_val);
        end
        @(negedge clk);
        act_v = {rsp_valid, rsp_err, rsp_offset, rsp_region, rsp_secondary, rsp_drive};
        nchk++;
        if (act_v !== exp_v) begin
            nerr++;
            $display("FAIL %s: actual v=%0b e=%0b off=%h rg=%0d sec=%0b drv=%0d expected v=%0b e=%0b off=%h rg=%0d sec=%0b drv=%0d",
                     tag, act_v[22], act_v[21], act_v[20:5], act_v[4:3], act_v[2], act_v[1:0],
                     exp_v[22], exp_v[21], exp_v[20:5], exp_v[4:3], exp_v[2], exp_v[1:0]);
        end
    endtask

    task automatic acc(input int a, input int sz, input bit wr, input int wb, input string tag);
        req_valid = 1'b1; req_addr = AW'(a); req_size = 3'(sz);
        req_write = wr; req_wbyte = 8'(wb);
        step(tag);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic setbar(input int idx, input int val, input string tag);
        bar_we = 1'b1; bar_idx = 3'(idx); bar_val = AW'(val);
        step(tag);
        bar_we = 1'b0;
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step("R11"); step("R11");
        rst_n = 1'b1; io_en = 1'b1;
        step("R11");
        // R10: program windows
        setbar(0, 'h1F0, "R10"); setbar(1, 'h3F4, "R10");
        setbar(2, 'h170, "R10"); setbar(3, 'h374, "R10");
        setbar(4, 'hC000, "R10");
        // R1: hits in every window
        acc('h1F0, 1, 0, 0, "R1"); acc('h1F7, 2, 0, 0, "R1");
        acc('h3F6, 1, 0, 0, "R1"); acc('h172, 2, 0, 0, "R1");
        acc('h377, 1, 1, 0, "R1"); acc('h1F8, 1, 0, 0, "R3");
        // R3: misses
        acc('h0500, 1, 0, 0, "R3"); acc('hC010, 1, 0, 0, "R3");
        // R4: bus-master split
        acc('hC000, 1, 0, 0, "R4"); acc('hC007, 1, 0, 0, "R4");
        acc('hC008, 1, 0, 0, "R4"); acc('hC00F, 2, 0, 0, "R4");
        // R5 / R6: select snoop and drive index
        acc('h1F6, 1, 1, 'h10, "R5"); acc('h1F0, 1, 0, 0, "R6");
        acc('h170, 1, 0, 0, "R6");   acc('h176, 1, 1, 'hF0, "R5");
        acc('hC009, 1, 0, 0, "R6");  acc('hC002, 1, 0, 0, "R6");
        acc('h1F6, 1, 1, 'hEF, "R5"); acc('h1F6, 1, 0, 'h10, "R5");
        acc('h1F1, 1, 0, 0, "R6");   acc('h3F6, 1, 1, 'h10, "R5");
        acc('h1F1, 1, 0, 0, "R5");   acc('h1F6, 4, 1, 'h10, "R5");
        acc('h1F1, 1, 0, 0, "R5");   acc('h172, 1, 0, 0, "R6");
        // R7 / R8: access widths
        acc('h1F0, 3, 0, 0, "R7"); acc('h1F0, 0, 0, 0, "R7");
        acc('hC004, 7, 0, 0, "R7"); acc('h3F4, 4, 0, 0, "R8");
        acc('hC004, 4, 0, 0, "R8"); acc('h3F4, 2, 0, 0, "R8");
        // R9: disabled decode
        io_en = 1'b0;
        acc('h1F6, 1, 1, 'h10, "R9"); acc('h0500, 3, 0, 0, "R9");
        io_en = 1'b1;
        acc('h1F0, 1, 0, 0, "R9");
        // R10 / R2: zero and bad-index loads, overlap priority
        setbar(0, 0, "R10"); acc('h1F3, 1, 0, 0, "R10");
        setbar(6, 'h0400, "R10"); acc('h0400, 1, 0, 0, "R10");
        setbar(2, 'h1F2, "R2"); acc('h1F3, 1, 0, 0, "R2");
        setbar(0, 'h1E0, "R2"); acc('h1F3, 1, 0, 0, "R2");
        acc('h1E5, 2, 0, 0, "R2");
        // back-to-back and idle cycles
        for (int i = 0; i < 4; i++) acc('hC000 + 4 * i, 4, 0, 0, "R4");
        step("R3"); step("R3");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule